// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is one timer channel. A free-running divider on the peripheral clock makes a one-cycle count enable at one of four fixed ratios. A 16-bit counter advances on that enable while the channel is running. When the counter equals a programmable compare value, the counter returns to zero on that same enable, and a sticky match flag is set. A match can also raise a DMA request level, and a separate enable bit decides whether it does.

Software reaches four registers through a single synchronous register port, chosen by a 2-bit select: control/status, run, count and compare. Read data is combinational from the select. Strobes are sampled on the rising clock edge.

The match flag uses a read-then-clear rule. It can be cleared only by writing 0 to its bit after the register has been read while the flag was 1. A match in the same cycle as the clearing write wins, and the flag stays set.

Top module: `cmt_channel`

## Requirements
- R1: After reset, select 0 (control/status) reads 0x0000, select 1 (run) reads 0x0000, select 2 (count) reads 0x0000, select 3 (compare) reads 0xFFFF, and `dma_req` and `match_flag` are 0.
- R2: In the control/status word, bits 15:8, 6:5 and 3:2 always read 0, whatever was written. Writing 0xFFFF with no flag set reads back 0x0013.
- R3: Control bits 1:0 pick the count rate: 00 divides the clock by 4, 01 by 8, 10 by 16 and 11 by 64. After the write that sets run bit 0, the count first becomes 1 on the N-th rising edge and advances once every N edges after that.
- R4: While run bit 0 is 0, the count holds its value and the divider is cleared. After a restart, the next increment again takes N edges.
- R5: On the enable at which the count equals the compare value, the count goes to 0 and the flag (control bit 7) becomes 1. Starting from 0, the match period is compare+1 enables.
- R6: A write to select 0 with bit 7 equal to 0 clears the flag only if an earlier read of select 0 saw the flag as 1. A write without that read leaves the flag set.
- R7: Writing 1 to control bit 7 never sets the flag.
- R8: If a match occurs on the same edge as a clearing write, the flag stays 1.
- R9: A match raises `dma_req` only when control bit 4 (request enable) is 1. With bit 4 at 0, a match sets the flag and `dma_req` stays 0.
- R10: Once raised, `dma_req` stays 1 until a `dma_ack` pulse or until the flag is cleared.
- R11: A software write to the count wins over an increment on the same edge.
- R12: The count and compare registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 control/status, 1 run, 2 count, 3 compare |
| reg_rd | input | 1 | Read strobe; arms the flag clear when select 0 is read with the flag at 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| dma_ack | input | 1 | Pulse that withdraws the DMA request |
| dma_req | output | 1 | DMA request level |
| match_flag | output | 1 | Current value of the sticky match flag |

## Verification
The assertions assume that the strobes, the select and the write data are known values whenever reset is released. They also assume that a read and a write are never issued on the same edge, because arming and clearing in one cycle is not defined. The bench changes every input only on the falling edge and never raises both strobes together. It pulses `dma_ack` for exactly one cycle. All random stimulus goes through the same write and read tasks, so the inputs stay inside these assumptions.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int CMT_DATA_W    = 16;
    localparam int CMT_DIV_W     = 6;
    localparam int CMT_FLAG_BIT  = 7;
    localparam int CMT_REQEN_BIT = 4;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_RUN   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_CMP   = 2'd3
    } cmt_sel_e;

    // divide ratio chosen by the two clock select bits
    function automatic int cmt_ratio(input logic [1:0] cks);
        case (cks)
            2'd0:    return 4;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int DIV_W = CMT_DIV_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] cks,
    output logic       tick
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_state_t;

    pre_state_t       s_d, s_q;
    logic [DIV_W-1:0] last_d;

    always_comb begin
        s_d    = s_q;
        tick   = 1'b0;
        last_d = DIV_W'(cmt_ratio(cks) - 1);
        if (!run) begin
            s_d.div = '0;
        end else if (s_q.div >= last_d) begin
            s_d.div = '0;
            tick    = 1'b1;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int                DATA_W   = CMT_DATA_W,
    parameter logic [DATA_W-1:0] CMP_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic              cmp_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] cmp,
    output logic              match
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] cmp;
    } ctr_state_t;

    ctr_state_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        match = tick && (s_q.cnt == s_q.cmp);
        if (cnt_wr) begin
            s_d.cnt = wdata;
        end else if (tick) begin
            s_d.cnt = match ? '0 : s_q.cnt + 1'b1;
        end
        if (cmp_wr) begin
            s_d.cmp = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.cmp <= CMP_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
    assign cmp = s_q.cmp;

endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
    import cmt_pkg::*;
#(
    parameter int DATA_W = CMT_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ctrl,
    input  logic              wr_ctrl,
    input  logic              wr_run,
    input  logic [DATA_W-1:0] wdata,
    input  logic              match,
    input  logic              dma_ack,
    output logic              flag,
    output logic              armed,
    output logic              req_en,
    output logic [1:0]        cks,
    output logic              run,
    output logic              dma_req
);

    typedef struct packed {
        logic       flag;
        logic       armed;
        logic       req_en;
        logic [1:0] cks;
        logic       run;
        logic       dma_req;
    } ctl_state_t;

    ctl_state_t s_d, s_q;
    logic       clr_d;

    always_comb begin
        s_d   = s_q;
        clr_d = wr_ctrl && !wdata[CMT_FLAG_BIT] && s_q.armed;

        // reading the flag as 1 arms the clear
        if (rd_ctrl && s_q.flag) s_d.armed = 1'b1;

        if (wr_ctrl) begin
            s_d.req_en = wdata[CMT_REQEN_BIT];
            s_d.cks    = wdata[1:0];
            s_d.armed  = 1'b0;
        end

        if (wr_run) s_d.run = wdata[0];

        // a match on the same edge outranks the clear
        if (clr_d) s_d.flag = 1'b0;
        if (match) s_d.flag = 1'b1;

        if (dma_ack || (clr_d && !match)) s_d.dma_req = 1'b0;
        if (match && s_q.req_en)          s_d.dma_req = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag    = s_q.flag;
    assign armed   = s_q.armed;
    assign req_en  = s_q.req_en;
    assign cks     = s_q.cks;
    assign run     = s_q.run;
    assign dma_req = s_q.dma_req;

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int                DATA_W   = CMT_DATA_W,
    parameter int                DIV_W    = CMT_DIV_W,
    parameter logic [DATA_W-1:0] CMP_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic              match_flag
);

    logic              tick;
    logic              match_evt;
    logic              armed;
    logic              req_en;
    logic [1:0]        cks;
    logic              run_on;
    logic [DATA_W-1:0] cnt_val;
    logic [DATA_W-1:0] cmp_val;
    logic              rd_ctrl, wr_ctrl, wr_run, wr_cnt, wr_cmp;

    always_comb begin
        rd_ctrl = reg_rd && (reg_sel == SEL_CTRL);
        wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
        wr_run  = reg_wr && (reg_sel == SEL_RUN);
        wr_cnt  = reg_wr && (reg_sel == SEL_COUNT);
        wr_cmp  = reg_wr && (reg_sel == SEL_CMP);
    end

    cmt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_on),
        .cks  (cks),
        .tick (tick)
    );

    cmt_counter #(.DATA_W(DATA_W), .CMP_INIT(CMP_INIT)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt_wr(wr_cnt),
        .cmp_wr(wr_cmp),
        .wdata (reg_wdata),
        .cnt   (cnt_val),
        .cmp   (cmp_val),
        .match (match_evt)
    );

    cmt_ctrl #(.DATA_W(DATA_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_ctrl(rd_ctrl),
        .wr_ctrl(wr_ctrl),
        .wr_run (wr_run),
        .wdata  (reg_wdata),
        .match  (match_evt),
        .dma_ack(dma_ack),
        .flag   (match_flag),
        .armed  (armed),
        .req_en (req_en),
        .cks    (cks),
        .run    (run_on),
        .dma_req(dma_req)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[CMT_FLAG_BIT]  = match_flag;
                reg_rdata[CMT_REQEN_BIT] = req_en;
                reg_rdata[1:0]           = cks;
            end
            SEL_RUN:   reg_rdata[0] = run_on;
            SEL_COUNT: reg_rdata = cnt_val;
            default:   reg_rdata = cmp_val;
        endcase
    end

endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              dma_ack,
    input logic              dma_req,
    input logic              match_flag,
    input logic              match_evt,
    input logic              armed,
    input logic              req_en,
    input logic              run_on,
    input logic [DATA_W-1:0] cnt_val
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> ((reg_rdata & 16'hFF6C) == 16'h0000));

    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_on && !(reg_wr && reg_sel == 2'd2)) |=> $stable(cnt_val));

    a_r5_wrap_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !(reg_wr && reg_sel == 2'd2)) |=> (cnt_val == '0));

    a_r6_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(match_flag) |-> $past(reg_wr && reg_sel == 2'd0 && !reg_wdata[7] && armed));

    a_r7_flag_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(match_evt));

    a_r8_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> match_flag);

    a_r9_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(match_evt && req_en));

    a_r10_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> ($past(dma_ack) || $fell(match_flag)));

    a_r11_write_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2) |=> (cnt_val == $past(reg_wdata)));

endmodule

bind cmt_channel cmt_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dma_ack   (dma_ack),
    .dma_req   (dma_req),
    .match_flag(match_flag),
    .match_evt (match_evt),
    .armed     (armed),
    .req_en    (req_en),
    .run_on    (run_on),
    .cnt_val   (cnt_val)
);

// File: tb/cmt_channel_bench.sv
module cmt_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        dma_ack = 1'b0;
    logic        dma_req;
    logic        match_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cmt_channel u_cmt_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_ack   (dma_ack),
        .dma_req   (dma_req),
        .match_flag(match_flag)
    );

    function automatic int ratio(input int sel);
        case (sel)
            0:       return 4;
            1:       return 8;
            2:       return 16;
            default: return 64;
        endcase
    endfunction

    function automatic int exp_count(input int k, input int n, input int c);
        return (k / n) % (c + 1);
    endfunction

    function automatic logic exp_flag(input int k, input int n, input int c);
        return (k / n) >= (c + 1);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_sel = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        reg_sel = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] a;
        logic [15:0] b;
        int          n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd0, v); chk("R1 ctrl", v, 16'h0000);
        peek(2'd1, v); chk("R1 run", v, 16'h0000);
        peek(2'd2, v); chk("R1 count", v, 16'h0000);
        peek(2'd3, v); chk("R1 compare", v, 16'hFFFF);
        chk("R1 dma_req", {15'd0, dma_req}, 16'd0);
        chk("R1 match_flag", {15'd0, match_flag}, 16'd0);

        // R12 readback
        a = 16'($urandom); b = 16'($urandom);
        wr(2'd3, a); wr(2'd2, b);
        peek(2'd3, v); chk("R12 compare", v, a);
        peek(2'd2, v); chk("R12 count", v, b);

        // R2 reserved bits, R7 writing 1 to flag
        wr(2'd0, 16'hFFFF);
        peek(2'd0, v); chk("R2 reserved", v, 16'h0013);
        chk("R7 flag port", {15'd0, match_flag}, 16'd0);
        wr(2'd0, 16'h0080);
        peek(2'd0, v); chk("R7 write one", v, 16'h0000);

        // R3 each divide ratio
        for (int s = 0; s < 4; s++) begin
            n = ratio(s);
            wr(2'd1, 16'h0000);
            wr(2'd3, 16'hFFFF);
            wr(2'd2, 16'h0000);
            wr(2'd0, 16'(s));
            wr(2'd1, 16'h0001);
            wait_n(3 * n - 1);
            peek(2'd2, v); chk($sformatf("R3 div%0d before", n), v, 16'd2);
            wait_n(1);
            peek(2'd2, v); chk($sformatf("R3 div%0d edge", n), v, 16'd3);
        end

        // R4 hold while stopped, prescaler cleared (ratio 64 still selected)
        wr(2'd1, 16'h0000);
        wait_n(300);
        peek(2'd2, v); chk("R4 hold", v, 16'd3);
        wr(2'd1, 16'h0001);
        wait_n(63);
        peek(2'd2, v); chk("R4 restart early", v, 16'd3);
        wait_n(1);
        peek(2'd2, v); chk("R4 restart edge", v, 16'd4);

        // R11 count write on a tick edge
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0001);
        wait_n(3);
        wr(2'd2, 16'h1234);
        peek(2'd2, v); chk("R11 write wins", v, 16'h1234);
        wait_n(3);
        peek(2'd2, v); chk("R11 hold", v, 16'h1234);
        wait_n(1);
        peek(2'd2, v); chk("R11 resume", v, 16'h1235);

        // R5 match with compare 2, R9 request enabled
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0010);
        wr(2'd3, 16'd2);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0001);
        wait_n(11);
        peek(2'd2, v); chk("R5 count at compare", v, 16'd2);
        chk("R5 flag before", {15'd0, match_flag}, 16'd0);
        wait_n(1);
        peek(2'd2, v); chk("R5 wrap", v, 16'd0);
        peek(2'd0, v); chk("R5 flag bit", v, 16'h0090);
        chk("R9 req enabled", {15'd0, dma_req}, 16'd1);
        wr(2'd1, 16'h0000);
        wait_n(5);
        chk("R10 req held", {15'd0, dma_req}, 16'd1);
        wr(2'd0, 16'h0010);
        chk("R6 no read no clear", {15'd0, match_flag}, 16'd1);
        dma_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dma_ack = 1'b0;
        chk("R10 ack drops req", {15'd0, dma_req}, 16'd0);
        chk("R10 ack keeps flag", {15'd0, match_flag}, 16'd1);
        rd(2'd0, v); chk("R6 read sees flag", v, 16'h0090);
        wr(2'd0, 16'h0010);
        chk("R6 clear after read", {15'd0, match_flag}, 16'd0);

        // R10 request dropped by flag clear
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0001);
        wait_n(12);
        wr(2'd1, 16'h0000);
        chk("R10 req up", {15'd0, dma_req}, 16'd1);
        rd(2'd0, v);
        wr(2'd0, 16'h0010);
        chk("R10 clear drops req", {15'd0, dma_req}, 16'd0);

        // R9 request disabled
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0001);
        wait_n(12);
        wr(2'd1, 16'h0000);
        chk("R9 flag set", {15'd0, match_flag}, 16'd1);
        chk("R9 no req", {15'd0, dma_req}, 16'd0);
        rd(2'd0, v);
        wr(2'd0, 16'h0000);

        // R8 match on the clearing edge
        wr(2'd3, 16'd0);
        wr(2'd2, 16'd0);
        wr(2'd1, 16'h0001);
        wait_n(4);
        rd(2'd0, v);
        wait_n(2);
        wr(2'd0, 16'h0000);
        chk("R8 flag kept", {15'd0, match_flag}, 16'd1);
        wr(2'd1, 16'h0000);
        rd(2'd0, v);
        wr(2'd0, 16'h0000);
        chk("R6 clear after R8", {15'd0, match_flag}, 16'd0);

        // random runs (R3 R5 R9)
        for (int it = 0; it < 12; it++) begin
            int s, c, k;
            logic en;
            s  = $urandom_range(0, 3);
            c  = $urandom_range(0, 4);
            en = 1'($urandom);
            n  = ratio(s);
            k  = $urandom_range(1, 3 * (c + 1) * n);
            wr(2'd1, 16'h0000);
            rd(2'd0, v);
            wr(2'd0, {11'd0, en, 2'd0, 2'(s)});
            wr(2'd3, 16'(c));
            wr(2'd2, 16'h0000);
            wr(2'd1, 16'h0001);
            wait_n(k);
            peek(2'd2, v); chk("R5 random count", v, 16'(exp_count(k, n, c)));
            chk("R5 random flag", {15'd0, match_flag}, {15'd0, exp_flag(k, n, c)});
            chk("R9 random req", {15'd0, dma_req}, {15'd0, exp_flag(k, n, c) && en});
        end

        finish_run();
    end

endmodule